// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Controller

This block makes two independent clock-enable strobes from one fast parent clock, one strobe per core domain. Each strobe runs at a rate set by a 5-bit reduction field `f`. The enable rate is parent × (32 − f) / 32 / 2. A field of 0 gives the full half rate, and a field of 31 gives one enable in every 64 parent cycles. The rate is produced by pulse swallowing. A phase accumulator picks the live slots of each 32-cycle frame and spreads them evenly. A toggle then passes every second live slot, which gives the fixed divide-by-two.

Software stages both fields through a simple register port. The staged values do nothing until a commit bit is set in a separate register. The hardware then copies the staged fields into the active dividers at the next 32-cycle frame boundary and clears the commit bit by itself. Software polls the commit bit, or the `busy` output, until it reads 0. While a commit is pending, the block ignores writes to the field register and further commit requests. Because the switch happens only at a frame boundary, no frame ever mixes two ratios.

Top module: `frac_clken`

## Requirements
- R1: After reset, both staged fields read 0, the commit register reads 0, `busy` is 0, and each domain gives 32 enables in 64 cycles.
- R2: The field register (address 0) holds the first domain's field in bits [12:8] and the second domain's field in bits [4:0]. All other bits read 0. The register read data appears one cycle after `rd_addr` is presented.
- R3: Writing the commit register (address 1) with bit 31 set while not busy sets `busy`, and bit 31 then reads 1. Writing it with bit 31 clear has no effect.
- R4: `busy` clears by itself at the first 32-cycle frame boundary after the commit, no more than 32 cycles after it was set. The active ratios change only at a frame boundary, and the new ratios take effect in the frame that starts there.
- R5: Writes to the field register while `busy` is 1 are ignored. Both the read-back value and the ratio committed afterwards keep the values staged before the commit.
- R6: Over any two consecutive whole frames, a domain with active field f gives exactly 32 − f enables.
- R7: An enable output is never high in two consecutive cycles.
- R8: The enables are evenly spaced. When 32 − f divides 32, the gap between consecutive enables is always 64 / (32 − f) cycles.
- R9: A field write without a commit leaves both enable rates unchanged.
- R10: Each domain's rate depends only on its own field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 = fields, 1 = commit) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data, one cycle after `rd_addr` |
| ena_a | output | 1 | Enable strobe for the first domain |
| ena_b | output | 1 | Enable strobe for the second domain |
| busy | output | 1 | Commit pending; mirrors bit 31 of the commit register |

## Verification
The assertions assume that software follows the commit protocol: fields are staged while the block is idle, and a new commit is requested only after `busy` has read 0. The assertions also assume that reset is held for at least one clock edge before any access. The bench always polls `busy` to 0 before it stages the next setting. It also deliberately writes fields during a pending commit and writes a zero commit, so that it can check that both are ignored. All bus inputs are driven on the falling edge, so each write is a single-cycle strobe with stable address and data.

// File: rtl/frac_clken_pkg.sv
package frac_clken_pkg;
  localparam int FIELD_W  = 5;
  localparam int FRAME    = 1 << FIELD_W;
  localparam int SLOT_W   = FIELD_W;
  localparam int ACC_W    = FIELD_W + 1;
  localparam int N_DOM    = 2;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int KICK_BIT = 31;
  // Bit position of each domain's field inside the field register.
  localparam int FIELD_LSB [N_DOM] = '{8, 0};
  localparam logic [ADDR_W-1:0] ADDR_FIELDS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_KICK   = 2'd1;

  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/frac_clken_frame.sv
module frac_clken_frame
  import frac_clken_pkg::*;
#(
  parameter int SW = SLOT_W
) (
  input  logic clk,
  input  logic rst,
  output logic frame_end
);
  logic [SW-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot + 1'b1;
  end

  // Last slot of a frame: the next edge starts a fresh frame.
  assign frame_end = &slot;
endmodule

// File: rtl/frac_clken_regs.sv
module frac_clken_regs
  import frac_clken_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int ND = N_DOM
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic [AW-1:0]               rd_addr,
  output logic [DW-1:0]               rd_data,
  input  logic                        frame_end,
  output logic                        busy,
  output logic [ND-1:0][FIELD_W-1:0]  staged,
  output logic [ND-1:0][FIELD_W-1:0]  active
);
  logic          idle_wr;
  logic          fld_wr;
  logic          kick_req;
  logic [DW-1:0] rd_mux;

  assign idle_wr  = wr_en && !busy;
  assign fld_wr   = idle_wr && (wr_addr == ADDR_FIELDS);
  assign kick_req = idle_wr && (wr_addr == ADDR_KICK) && wr_data[KICK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
      active <= '0;
      busy   <= 1'b0;
    end else begin
      if (fld_wr) begin
        for (int d = 0; d < ND; d++)
          staged[d] <= wr_data[FIELD_LSB[d] +: FIELD_W];
      end
      if (busy && frame_end) begin
        active <= staged;
        busy   <= 1'b0;
      end else if (kick_req) begin
        busy <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_FIELDS: begin
        for (int d = 0; d < ND; d++)
          rd_mux[FIELD_LSB[d] +: FIELD_W] = staged[d];
      end
      ADDR_KICK: rd_mux[KICK_BIT] = busy;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/frac_clken_lane.sv
module frac_clken_lane
  import frac_clken_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int AW = FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] field,
  output logic          ena
);
  localparam logic [AW-1:0] FRAME_N = AW'(1 << FW);

  logic [AW-1:0] acc;
  logic [AW-1:0] step;
  logic [AW-1:0] sum;
  logic          hit;
  logic          phase;

  // Live slots per frame: 32 - field, in 1..32.
  assign step = FRAME_N - {1'b0, field};
  assign sum  = acc + step;
  assign hit  = (sum >= FRAME_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      phase <= 1'b0;
      ena   <= 1'b0;
    end else begin
      acc   <= hit ? (sum - FRAME_N) : sum;
      phase <= phase ^ hit;
      ena   <= hit & phase;
    end
  end
endmodule

// File: rtl/frac_clken.sv
module frac_clken
  import frac_clken_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          ena_a,
  output logic          ena_b,
  output logic          busy
);
  logic                           frame_end;
  logic [N_DOM-1:0][FIELD_W-1:0]  staged;
  logic [N_DOM-1:0][FIELD_W-1:0]  active;
  logic [N_DOM-1:0]               ena;

  frac_clken_frame #(.SW(SLOT_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end)
  );

  frac_clken_regs #(.DW(DW), .AW(AW), .ND(N_DOM)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .frame_end (frame_end),
    .busy      (busy),
    .staged    (staged),
    .active    (active)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_lane
    frac_clken_lane #(.FW(FIELD_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .field (active[d]),
      .ena   (ena[d])
    );
  end

  assign ena_a = ena[0];
  assign ena_b = ena[1];
endmodule

// File: rtl/frac_clken_chk.sv
module frac_clken_chk
  import frac_clken_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [AW-1:0]                 wr_addr,
  input logic [DW-1:0]                 wr_data,
  input logic                          busy,
  input logic                          ena_a,
  input logic                          ena_b,
  input logic                          frame_end,
  input logic [N_DOM-1:0][FIELD_W-1:0] staged,
  input logic [N_DOM-1:0][FIELD_W-1:0] active
);
  logic [SLOT_W+1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_kick_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_addr == ADDR_KICK && wr_data[KICK_BIT]) |=> busy);

  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= (SLOT_W+2)'(FRAME));

  assert_release_at_frame_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(frame_end));

  assert_active_only_at_frame_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_end) |-> $stable(active));

  assert_stage_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(staged));

  assert_no_back_to_back_a_R7: assert property (@(posedge clk) disable iff (rst)
    ena_a |=> !ena_a);

  assert_no_back_to_back_b_R7: assert property (@(posedge clk) disable iff (rst)
    ena_b |=> !ena_b);
endmodule

bind frac_clken frac_clken_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy),
  .ena_a     (ena_a),
  .ena_b     (ena_b),
  .frame_end (frame_end),
  .staged    (staged),
  .active    (active)
);

// File: tb/test_frac_clken.sv
module test_frac_clken;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ena_a, ena_b, busy;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  frac_clken i_frac_clken (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ena_a(ena_a), .ena_b(ena_b), .busy(busy)
  );

  // {first domain field, second domain field}
  localparam logic [9:0] VEC [0:5] = '{
    {5'd0,  5'd0},
    {5'd16, 5'd24},
    {5'd31, 5'd1},
    {5'd8,  5'd30},
    {5'd24, 5'd16},
    {5'd1,  5'd31}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [31:0] pack(input int fa, input int fb);
    return (32'(fa) << 8) | 32'(fb);
  endfunction

  // Called at a negedge with busy already high; returns at the negedge where busy reads 0.
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Counts enables over 64 cycles = two whole frames when called right after commit.
  task automatic measure(output int ca, output int cb, output int mina, output int maxa,
                         output int minb, output int maxb);
    int la, lb;
    ca = 0; cb = 0; la = -1; lb = -1;
    mina = 1000; maxa = 0; minb = 1000; maxb = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (ena_a) begin
        if (la >= 0) begin
          if (k - la < mina) mina = k - la;
          if (k - la > maxa) maxa = k - la;
        end
        la = k; ca++;
      end
      if (ena_b) begin
        if (lb >= 0) begin
          if (k - lb < minb) minb = k - lb;
          if (k - lb > maxb) maxb = k - lb;
        end
        lb = k; cb++;
      end
    end
  endtask

  task automatic commit_and_check(input int fa, input int fb, input string tag);
    logic [31:0] d;
    int n, ca, cb, mina, maxa, minb, maxb, ma, mb;
    wr(2'd0, pack(fa, fb));
    rd(2'd0, d);
    check(d == pack(fa, fb), "R2 field readback", int'(d), int'(pack(fa, fb)));
    wr(2'd1, 32'h8000_0000);
    check(busy == 1'b1, "R3 busy after kick", int'(busy), 1);
    rd(2'd1, d);
    check(d == 32'h8000_0000 || busy == 1'b0, "R3 kick bit reads 1", int'(d), 32'h8000_0000);
    wait_idle(n);
    check(n <= 32, "R4 busy self-clears within frame", n, 32);
    measure(ca, cb, mina, maxa, minb, maxb);
    ma = 32 - fa; mb = 32 - fb;
    check(ca == ma, {"R6 R10 count a ", tag}, ca, ma);
    check(cb == mb, {"R6 R10 count b ", tag}, cb, mb);
    if (ca >= 2) check(mina >= 2, "R7 gap a", mina, 2);
    if (cb >= 2) check(minb >= 2, "R7 gap b", minb, 2);
    if (32 % ma == 0 && ca >= 2)
      check(mina == 64 / ma && maxa == 64 / ma, "R8 even spacing a", maxa, 64 / ma);
    if (32 % mb == 0 && cb >= 2)
      check(minb == 64 / mb && maxb == 64 / mb, "R8 even spacing b", maxb, 64 / mb);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int n, ca, cb, mina, maxa, minb, maxb;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    rd(2'd0, d);
    check(d == 32'h0, "R1 fields after reset", int'(d), 0);
    rd(2'd1, d);
    check(d == 32'h0, "R1 kick after reset", int'(d), 0);
    measure(ca, cb, mina, maxa, minb, maxb);
    check(ca == 32, "R1 default rate a", ca, 32);
    check(cb == 32, "R1 default rate b", cb, 32);

    // R2: unused bits read 0
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    check(d == 32'h0000_1F1F, "R2 only field bits stored", int'(d), 32'h1F1F);

    // Table of settings
    for (int i = 0; i < 6; i++)
      commit_and_check(int'(VEC[i][9:5]), int'(VEC[i][4:0]), $sformatf("vec%0d", i));

    // R3: writing 0 to the kick bit does nothing
    wr(2'd1, 32'h7FFF_FFFF);
    check(busy == 1'b0, "R3 zero kick no busy", int'(busy), 0);
    rd(2'd1, d);
    check(d == 32'h0, "R3 zero kick reads 0", int'(d), 0);

    // R9: staging without commit leaves rates unchanged (active is still 1,31)
    wr(2'd0, pack(0, 0));
    @(negedge clk);
    while (i_frac_clken.busy) @(negedge clk);
    rd(2'd0, d);
    check(d == pack(0, 0), "R9 staged readback", int'(d), int'(pack(0, 0)));
    repeat (40) @(negedge clk);
    measure(ca, cb, mina, maxa, minb, maxb);
    check(ca >= 30 && ca <= 31, "R9 rate a unchanged", ca, 31);
    check(cb >= 1 && cb <= 2, "R9 rate b unchanged", cb, 1);

    // R5: field write while busy is ignored
    wr(2'd0, pack(10, 6));
    wr(2'd1, 32'h8000_0000);
    check(busy == 1'b1, "R5 busy before ignored write", int'(busy), 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = pack(0, 0);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check(busy == 1'b1, "R5 still busy", int'(busy), 1);
    wait_idle(n);
    check(n <= 32, "R4 busy bound in R5 test", n, 32);
    measure(ca, cb, mina, maxa, minb, maxb);
    check(ca == 22, "R5 committed rate a", ca, 22);
    check(cb == 26, "R5 committed rate b", cb, 26);
    rd(2'd0, d);
    check(d == pack(10, 6), "R5 readback keeps staged", int'(d), int'(pack(10, 6)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule